// File: doc/BRIEF.md
# Radix Page-Table Walker

This block resolves an effective address through a hierarchical radix page table whose depth is not fixed. Each level of the tree declares how many index bits the following level uses. A walk is launched by a one-cycle start pulse. The caller supplies one of two starting points. The first is a root directly: its base address, its index width and the total size of the address space in bits. The second is a process table: its base, its size code and a process identifier. In that case the root is first read from the process table.

The walker then reads one 64-bit entry per level over a request/acknowledge memory port. It descends through directory entries until it reaches a leaf, an invalid entry, a bad configuration or the depth limit. It finishes with a one-cycle done pulse. On success it presents the translated real address, the page size in bits, the leaf entry and the address that leaf was read from. On failure it presents a fault flag and a cause code. Permission checks and any second translation stage of the table addresses belong to other blocks.

Entry layout is fixed:
- bit 63 is valid and bit 62 is leaf.
- In a directory entry, bits 55:8 give the next table base (low 8 bits zero) and bits 4:0 give the next index width.
- In a leaf, bits 55:12 give the page number in place.
- In a process-table entry, bits 62:56 give the address-space size, bits 55:8 the root base and bits 4:0 the root index width.

Top module: `rdx_walker`

## Requirements
- R1: After reset, and whenever no walk is running, `busy`, `done` and `rd_req` are all low.
- R2: When a level's index width is below 5, or is larger than the bits of address space that remain, the walk ends with cause 1 (bad configuration). No read is issued for that level.
- R3: The read address for a level is base + 8 × ((eaddr >> (remaining − width)) & (2^width − 1)). Every read address is a multiple of 8.
- R4: An entry read with bit 63 clear ends the walk with cause 2 (no entry).
- R5: A valid directory entry (bit 62 clear) has its width subtracted from the remaining size. It supplies the next base (bits 55:8) and the next width (bits 4:0), and the walk continues.
- R6: A valid leaf (bit 62 set) ends the walk with cause 0. `page_bits` is the remaining size after this level's width is subtracted. `real_addr` takes the page-number bits at and above `page_bits` and the eaddr bits below it. `leaf_entry` and `entry_addr` report the leaf and where it was read.
- R7: In process-table mode, the offset is pid × 16 and the table holds 2^(size code + 12) bytes. An offset at or beyond that size ends the walk with cause 2 and no read. Otherwise the entry at base + offset is read and used as the root without a valid check.
- R8: A directory entry found at the 8th level ends the walk with cause 3 (depth overflow). A leaf at the 8th level still completes normally.
- R9: Once `rd_req` is raised, it stays high with `rd_addr` unchanged until the cycle in which `rd_ack` is seen.
- R10: All launch inputs are captured at start. A start pulse while `busy` is high is ignored.
- R11: `done` is high for exactly one cycle per walk. `fault` equals (fault_cause ≠ 0) whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| use_prtab | input | 1 | 1: fetch root from the process table first |
| eaddr | input | 64 | Effective address to translate |
| root_base | input | 64 | Root table base (direct mode) |
| root_nls | input | 5 | Root index width (direct mode) |
| space_bits | input | 7 | Address-space size in bits (direct mode) |
| prtab_base | input | 64 | Process-table base |
| prtab_szc | input | 5 | Process-table size code |
| pid | input | PID_W | Process identifier |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 64 | Read response data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 none, 1 bad config, 2 no entry, 3 depth |
| real_addr | output | 64 | Translated real address |
| page_bits | output | 7 | Page size in address bits |
| leaf_entry | output | 64 | Leaf entry read |
| entry_addr | output | 64 | Address of the leaf entry |

## Verification
Two decisions can be taken on the same memory response. At the 8th level, one response must decide between completing on a leaf and faulting on the depth limit. A second start pulse can also arrive in the very cycle a read is pending, or a walk is finishing. Directed chains of exactly seven directory levels followed by either a leaf or an eighth directory provoke the first collision. Start pulses injected while `busy` is high, with the launch inputs scrambled, provoke the second. Each walk is judged against a bench model of the same table, which predicts the cause, the read count and the result fields. After `done`, the bench also confirms that no second walk was launched.

// File: rtl/rdx_pkg.sv
`timescale 1ns/1ps
package rdx_pkg;
  localparam int EW        = 64;
  localparam int NLS_W     = 5;
  localparam int SZ_W      = 7;
  localparam int MIN_NLS   = 5;
  localparam int IDX_SHIFT = 3;   // 8-byte entries
  localparam int PT_SHIFT  = 4;   // 16-byte process-table entries
  localparam int PT_LOG    = 12;  // process table size = 2^(code+12)
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam logic [EW-1:0] BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [EW-1:0] RPN_MASK  = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BADCFG = 2'd1,
    CAUSE_NOENT  = 2'd2,
    CAUSE_DEPTH  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_REQ   = 2'd2
  } state_e;

  typedef struct packed {
    logic             valid;
    logic             leaf;
    logic [EW-1:0]    next_base;
    logic [NLS_W-1:0] next_nls;
    logic [EW-1:0]    rpn;
  } entry_t;

  // width illegal at this level
  function automatic logic nls_illegal(input logic [NLS_W-1:0] nls,
                                       input logic [SZ_W-1:0]  rem);
    return (nls < NLS_W'(MIN_NLS)) || (SZ_W'(nls) > rem);
  endfunction

  // entry address for one level of the tree
  function automatic logic [EW-1:0] slot_addr(input logic [EW-1:0]    base,
                                              input logic [EW-1:0]    ea,
                                              input logic [SZ_W-1:0]  rem,
                                              input logic [NLS_W-1:0] nls);
    logic [SZ_W-1:0] sh;
    logic [EW-1:0]   idx;
    sh  = rem - SZ_W'(nls);
    idx = (ea >> sh) & ((EW'(1) << nls) - EW'(1));
    return base + (idx << IDX_SHIFT);
  endfunction

  // process-table offset bounds check
  function automatic logic pt_in_range(input logic [EW-1:0]    off,
                                       input logic [NLS_W-1:0] code);
    logic [SZ_W-1:0] lg;
    lg = SZ_W'(code) + SZ_W'(PT_LOG);
    return off < (EW'(1) << lg);
  endfunction

  // page number above the page boundary, effective address below it
  function automatic logic [EW-1:0] merge_addr(input logic [EW-1:0]   rpn,
                                               input logic [EW-1:0]   ea,
                                               input logic [SZ_W-1:0] bits);
    logic [EW-1:0] mask;
    if (bits >= SZ_W'(EW)) mask = '1;
    else                   mask = (EW'(1) << bits) - EW'(1);
    return (rpn & ~mask) | (ea & mask);
  endfunction
endpackage

// File: rtl/rdx_slot_gen.sv
`timescale 1ns/1ps
module rdx_slot_gen
  import rdx_pkg::*;
#(
  parameter int PID_W = 16
) (
  input  logic [EW-1:0]    ea,
  input  logic [EW-1:0]    walk_base,
  input  logic [NLS_W-1:0] walk_nls,
  input  logic [SZ_W-1:0]  walk_rem,
  input  logic [EW-1:0]    pt_base,
  input  logic [NLS_W-1:0] pt_code,
  input  logic [PID_W-1:0] pt_pid,
  output logic [EW-1:0]    walk_addr,
  output logic             walk_cfg_bad,
  output logic [EW-1:0]    pt_addr,
  output logic             pt_ok
);
  logic [EW-1:0] pt_off;

  always_comb begin
    pt_off       = EW'(pt_pid) << PT_SHIFT;
    pt_ok        = pt_in_range(pt_off, pt_code);
    pt_addr      = pt_base + pt_off;
    walk_cfg_bad = nls_illegal(walk_nls, walk_rem);
    walk_addr    = slot_addr(walk_base, ea, walk_rem, walk_nls);
  end
endmodule

// File: rtl/rdx_entry_dec.sv
`timescale 1ns/1ps
module rdx_entry_dec
  import rdx_pkg::*;
(
  input  logic [EW-1:0]    data,
  output entry_t           ent,
  output logic [EW-1:0]    root_base,
  output logic [NLS_W-1:0] root_nls,
  output logic [SZ_W-1:0]  root_size
);
  always_comb begin
    ent.valid     = data[VALID_BIT];
    ent.leaf      = data[LEAF_BIT];
    ent.next_base = data & BASE_MASK;
    ent.next_nls  = data[NLS_W-1:0];
    ent.rpn       = data & RPN_MASK;
    root_base     = data & BASE_MASK;
    root_nls      = data[NLS_W-1:0];
    root_size     = data[LEAF_BIT:LEAF_BIT-SZ_W+1];
  end
endmodule

// File: rtl/rdx_leaf_merge.sv
`timescale 1ns/1ps
module rdx_leaf_merge
  import rdx_pkg::*;
(
  input  logic [EW-1:0]   rpn,
  input  logic [EW-1:0]   ea,
  input  logic [SZ_W-1:0] bits,
  output logic [EW-1:0]   raddr
);
  assign raddr = merge_addr(rpn, ea, bits);
endmodule

// File: rtl/rdx_walker.sv
`timescale 1ns/1ps
module rdx_walker
  import rdx_pkg::*;
#(
  parameter int PID_W   = 16,
  parameter int MAX_LVL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_prtab,
  input  logic [63:0]      eaddr,
  input  logic [63:0]      root_base,
  input  logic [4:0]       root_nls,
  input  logic [6:0]       space_bits,
  input  logic [63:0]      prtab_base,
  input  logic [4:0]       prtab_szc,
  input  logic [PID_W-1:0] pid,
  output logic             rd_req,
  output logic [63:0]      rd_addr,
  input  logic             rd_ack,
  input  logic [63:0]      rd_data,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_cause,
  output logic [63:0]      real_addr,
  output logic [6:0]       page_bits,
  output logic [63:0]      leaf_entry,
  output logic [63:0]      entry_addr
);
  localparam int LVL_W = $clog2(MAX_LVL + 1);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LVL - 1);

  state_e           st, st_n;
  logic [EW-1:0]    ea_q, base_q, addr_q;
  logic [NLS_W-1:0] nls_q;
  logic [SZ_W-1:0]  rem_q, rem_after;
  logic [LVL_W-1:0] lvl_q;
  logic             pt_phase;

  // named internal events
  logic   ev_launch_pt, ev_launch_walk, ev_issue, ev_take_root, ev_take_next;
  logic   ev_leaf, ev_fin;
  cause_e fin_cause;

  logic [EW-1:0]    walk_addr, pt_addr, merged;
  logic             cfg_bad, pt_ok;
  entry_t           ent;
  logic [EW-1:0]    rt_base;
  logic [NLS_W-1:0] rt_nls;
  logic [SZ_W-1:0]  rt_size;

  rdx_slot_gen #(.PID_W(PID_W)) u_slot (
    .ea          (ea_q),
    .walk_base   (base_q),
    .walk_nls    (nls_q),
    .walk_rem    (rem_q),
    .pt_base     (prtab_base),
    .pt_code     (prtab_szc),
    .pt_pid      (pid),
    .walk_addr   (walk_addr),
    .walk_cfg_bad(cfg_bad),
    .pt_addr     (pt_addr),
    .pt_ok       (pt_ok)
  );

  rdx_entry_dec u_dec (
    .data     (rd_data),
    .ent      (ent),
    .root_base(rt_base),
    .root_nls (rt_nls),
    .root_size(rt_size)
  );

  assign rem_after = rem_q - SZ_W'(nls_q);

  rdx_leaf_merge u_merge (
    .rpn  (ent.rpn),
    .ea   (ea_q),
    .bits (rem_after),
    .raddr(merged)
  );

  always_comb begin
    st_n           = st;
    ev_launch_pt   = 1'b0;
    ev_launch_walk = 1'b0;
    ev_issue       = 1'b0;
    ev_take_root   = 1'b0;
    ev_take_next   = 1'b0;
    ev_leaf        = 1'b0;
    ev_fin         = 1'b0;
    fin_cause      = CAUSE_NONE;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          if (use_prtab) begin
            if (pt_ok) begin
              ev_launch_pt = 1'b1;
              st_n         = ST_REQ;
            end else begin
              ev_fin    = 1'b1;
              fin_cause = CAUSE_NOENT;
            end
          end else begin
            ev_launch_walk = 1'b1;
            st_n           = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (cfg_bad) begin
          ev_fin    = 1'b1;
          fin_cause = CAUSE_BADCFG;
        end else begin
          ev_issue = 1'b1;
          st_n     = ST_REQ;
        end
      end
      ST_REQ: begin
        if (rd_ack) begin
          if (pt_phase) begin
            ev_take_root = 1'b1;
            st_n         = ST_CHECK;
          end else if (!ent.valid) begin
            ev_fin    = 1'b1;
            fin_cause = CAUSE_NOENT;
          end else if (ent.leaf) begin
            ev_fin  = 1'b1;
            ev_leaf = 1'b1;
          end else if (lvl_q == LAST_LVL) begin
            ev_fin    = 1'b1;
            fin_cause = CAUSE_DEPTH;
          end else begin
            ev_take_next = 1'b1;
            st_n         = ST_CHECK;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (ev_fin) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      ea_q        <= '0;
      base_q      <= '0;
      addr_q      <= '0;
      nls_q       <= '0;
      rem_q       <= '0;
      lvl_q       <= '0;
      pt_phase    <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= '0;
      real_addr   <= '0;
      page_bits   <= '0;
      leaf_entry  <= '0;
      entry_addr  <= '0;
    end else begin
      st   <= st_n;
      done <= ev_fin;
      if (ev_launch_pt || ev_launch_walk) begin
        ea_q     <= eaddr;
        lvl_q    <= '0;
        pt_phase <= ev_launch_pt;
      end
      if (ev_launch_pt) addr_q <= pt_addr;
      if (ev_launch_walk) begin
        base_q <= root_base;
        nls_q  <= root_nls;
        rem_q  <= space_bits;
      end
      if (ev_issue) addr_q <= walk_addr;
      if (ev_take_root) begin
        base_q   <= rt_base;
        nls_q    <= rt_nls;
        rem_q    <= rt_size;
        pt_phase <= 1'b0;
      end
      if (ev_take_next) begin
        base_q <= ent.next_base;
        nls_q  <= ent.next_nls;
        rem_q  <= rem_after;
        lvl_q  <= lvl_q + LVL_W'(1);
      end
      if (ev_fin) begin
        fault       <= (fin_cause != CAUSE_NONE);
        fault_cause <= fin_cause;
      end
      if (ev_leaf) begin
        real_addr  <= merged;
        page_bits  <= rem_after;
        leaf_entry <= rd_data;
        entry_addr <= addr_q;
      end
    end
  end

  assign rd_req  = (st == ST_REQ);
  assign rd_addr = addr_q;
  assign busy    = (st != ST_IDLE);
endmodule

// File: rtl/rdx_walker_chk.sv
`timescale 1ns/1ps
module rdx_walker_chk
  import rdx_pkg::*;
#(
  parameter int MAX_LVL = 8,
  parameter int LVL_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rd_req,
  input logic [63:0]      rd_addr,
  input logic             rd_ack,
  input logic             done,
  input logic             fault,
  input logic [1:0]       fault_cause,
  input logic [LVL_W-1:0] lvl
);
  // R9: request held with a stable address until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R3: every read lands on an 8-byte boundary
  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[2:0] == 3'b000));

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: fault flag agrees with the cause
  a_r11_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == (fault_cause != 2'(CAUSE_NONE))));

  // R8: level counter never passes the depth bound
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lvl < LVL_W'(MAX_LVL)));

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  // R2: a bad-configuration end is not preceded by a pending read
  a_r2_badcfg_noread: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_cause == 2'(CAUSE_BADCFG)) |-> !$past(rd_req));
endmodule

bind rdx_walker rdx_walker_chk #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_ack     (rd_ack),
  .done       (done),
  .fault      (fault),
  .fault_cause(fault_cause),
  .lvl        (lvl_q)
);

// File: tb/tb_rdx_walker.sv
`timescale 1ns/1ps
module tb_rdx_walker;
  localparam int PID_W = 16;
  localparam logic [63:0] NLB = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN = 64'h00FF_FFFF_FFFF_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start = 0, use_prtab = 0;
  logic [63:0]      eaddr = 0, root_base = 0, prtab_base = 0;
  logic [4:0]       root_nls = 0, prtab_szc = 0;
  logic [6:0]       space_bits = 0;
  logic [PID_W-1:0] pid = 0;
  logic             rd_req, rd_ack = 1'b0;
  logic [63:0]      rd_addr, rd_data = 64'h0;
  logic             busy, done, fault;
  logic [1:0]       fault_cause;
  logic [63:0]      real_addr, leaf_entry, entry_addr;
  logic [6:0]       page_bits;

  rdx_walker #(.PID_W(PID_W), .MAX_LVL(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_prtab(use_prtab),
    .eaddr(eaddr), .root_base(root_base), .root_nls(root_nls),
    .space_bits(space_bits), .prtab_base(prtab_base), .prtab_szc(prtab_szc),
    .pid(pid), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .busy(busy), .done(done), .fault(fault),
    .fault_cause(fault_cause), .real_addr(real_addr), .page_bits(page_bits),
    .leaf_entry(leaf_entry), .entry_addr(entry_addr)
  );

  logic [63:0] mem [logic [63:0]];
  int checks = 0, errors = 0, reads = 0, hold_err = 0;
  logic pend = 1'b0;
  logic [63:0] first_addr = 64'h0;

  // test setup
  logic [63:0] t_ea, t_rbase, t_ptbase;
  int          t_space, t_rnls, t_nn, t_szc;
  bit          t_use_pt;
  logic [PID_W-1:0] t_pid;
  // expected
  int          e_cause, e_reads, e_pb;
  logic [63:0] e_raddr, e_leaf, e_paddr;

  function automatic logic [63:0] peek(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // memory responder with random latency
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (!pend) begin pend = 1'b1; first_addr = rd_addr; end
      else if (rd_addr !== first_addr) hold_err++;
      if ($urandom % 3 != 0) begin
        rd_ack  = 1'b1;
        rd_data = peek(rd_addr);
        reads++;
        pend = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lvl_slot(input logic [63:0] b, input int r, input int n);
    logic [63:0] idx;
    idx = 0;
    for (int k = 0; k < n; k++) idx[k] = t_ea[r - n + k];
    return b + idx * 8;
  endfunction

  // reference walk over the bench memory
  task automatic ref_walk();
    logic [63:0] b, a, e, w, off;
    int r, n;
    e_reads = 0; e_cause = 0;
    if (t_use_pt) begin
      off = 64'(t_pid) * 16;
      if (off >= (64'd1 << (t_szc + 12))) begin e_cause = 2; return; end
      w = peek(t_ptbase + off); e_reads = 1;
      r = int'(w[62:56]); b = {8'h0, w[55:8], 8'h0}; n = int'(w[4:0]);
    end else begin
      r = t_space; b = t_rbase; n = t_rnls;
    end
    for (int lv = 0; lv < 8; lv++) begin
      if (n < 5 || n > r) begin e_cause = 1; return; end
      a = lvl_slot(b, r, n);
      e = peek(a); e_reads++;
      if (!e[63]) begin e_cause = 2; return; end
      r = r - n;
      if (e[62]) begin
        for (int k = 0; k < 64; k++) e_raddr[k] = (k < r) ? t_ea[k] : ((k >= 12 && k <= 55) ? e[k] : 1'b0);
        e_pb = r; e_leaf = e; e_paddr = a;
        return;
      end
      if (lv == 7) begin e_cause = 3; return; end
      b = {8'h0, e[55:8], 8'h0}; n = int'(e[4:0]);
    end
  endtask

  task automatic put_pt();
    mem[t_ptbase + 64'(t_pid) * 16] = (64'(t_space) << 56) | (t_rbase & NLB) | 64'(t_rnls);
  endtask

  // fixed chain: nonleafs directory levels then last (0 leaf, 1 invalid, 2 directory)
  task automatic build_chain(input int nonleafs, input int last);
    logic [63:0] b, a, nb;
    int r, n;
    b = t_rbase; n = t_rnls; r = t_space;
    for (int i = 0; i <= nonleafs; i++) begin
      if (n < 5 || n > r) return;
      a = lvl_slot(b, r, n);
      if (i < nonleafs || last == 2) begin
        nb = rnd64() & NLB;
        mem[a] = (64'd1 << 63) | nb | 64'(t_nn);
        b = nb; r = r - n; n = t_nn;
      end else if (last == 0) mem[a] = (64'd3 << 62) | (rnd64() & RPN);
      else mem[a] = rnd64() & ~(64'd1 << 63);
    end
  endtask

  task automatic build_random();
    logic [63:0] b, a, nb;
    int r, n, nn, roll;
    mem.delete();
    t_ea = rnd64(); t_use_pt = ($urandom % 3 == 0);
    t_space = 20 + $urandom % 40; t_rnls = 5 + $urandom % 5;
    if ($urandom % 20 == 0) t_rnls = $urandom % 5;
    t_rbase = rnd64() & NLB; t_ptbase = rnd64() & NLB;
    t_szc = $urandom % 4; t_pid = PID_W'($urandom % (1 << (t_szc + 9)));
    if (t_use_pt) put_pt();
    b = t_rbase; n = t_rnls; r = t_space;
    for (int lv = 0; lv < 9; lv++) begin
      if (n < 5 || n > r) break;
      a = lvl_slot(b, r, n); roll = $urandom % 10;
      if (roll == 0) begin mem[a] = rnd64() & ~(64'd1 << 63); break; end
      if (roll < 4 || r - n < 5) begin mem[a] = (64'd3 << 62) | (rnd64() & RPN); break; end
      nn = 5 + $urandom % 6; if ($urandom % 15 == 0) nn = $urandom % 5;
      nb = rnd64() & NLB;
      mem[a] = (64'd1 << 63) | nb | 64'(nn);
      b = nb; r = r - n; n = nn;
    end
  endtask

  task automatic run_walk(input string tag, input bit poke);
    bit poked;
    string tc;
    poked = 0;
    ref_walk();
    @(negedge clk);
    eaddr = t_ea; root_base = t_rbase; root_nls = 5'(t_rnls); space_bits = 7'(t_space);
    use_prtab = t_use_pt; prtab_base = t_ptbase; prtab_szc = 5'(t_szc); pid = t_pid;
    start = 1'b1; reads = 0;
    @(negedge clk);
    start = 1'b0;
    // R10: launch inputs must already be captured
    eaddr = ~t_ea; root_base = rnd64() & NLB; root_nls = 5'(7); space_bits = 7'(50);
    use_prtab = ~t_use_pt; pid = ~t_pid; prtab_szc = 5'(30);
    while (!done) begin
      start = poke && busy && !poked;
      if (start) poked = 1;
      @(negedge clk);
      start = 1'b0;
    end
    tc = (e_cause == 1) ? "R2" : (e_cause == 2) ? ((t_use_pt && e_reads == 0) ? "R7" : "R4")
       : (e_cause == 3) ? "R8" : tag;
    chk(tc, "cause", 64'(fault_cause), 64'(e_cause));
    chk("R11", "fault", 64'(fault), 64'(e_cause != 0));
    chk(tc, "reads", 64'(reads), 64'(e_reads));
    if (e_cause == 0) begin
      chk("R6", "real_addr", real_addr, e_raddr);
      chk("R6", "page_bits", 64'(page_bits), 64'(e_pb));
      chk("R6", "leaf_entry", leaf_entry, e_leaf);
      chk("R3", "entry_addr", entry_addr, e_paddr);
    end
    @(negedge clk);
    chk("R11", "done_width", 64'(done), 64'd0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R10", "busy_after", 64'(busy), 64'd0);
    end
  endtask

  task automatic base_setup(input int space, input int rnls, input int nn);
    mem.delete();
    t_ea = rnd64(); t_use_pt = 0; t_space = space; t_rnls = rnls; t_nn = nn;
    t_rbase = rnd64() & NLB; t_ptbase = rnd64() & NLB; t_szc = 0; t_pid = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "busy_reset", 64'(busy), 64'd0);
    chk("R1", "done_reset", 64'(done), 64'd0);
    chk("R1", "req_reset", 64'(rd_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_idle", 64'(rd_req), 64'd0);

    base_setup(40, 4, 6);  build_chain(0, 0); run_walk("R2", 0);
    base_setup(8, 10, 6);  build_chain(0, 0); run_walk("R2", 0);
    base_setup(40, 9, 6);  build_chain(0, 0); run_walk("R3", 0);
    base_setup(40, 9, 6);  build_chain(0, 1); run_walk("R4", 0);
    base_setup(44, 9, 7);  build_chain(1, 0); run_walk("R5", 0);
    base_setup(44, 9, 3);  build_chain(1, 0); run_walk("R2", 0);
    // R8: leaf at the 8th level versus directory at the 8th level
    base_setup(60, 5, 5);  build_chain(7, 0); run_walk("R8", 0);
    chk("R8", "leaf_at_limit", 64'(fault_cause), 64'd0);
    base_setup(60, 5, 5);  build_chain(7, 2); run_walk("R8", 0);
    // R7: process table boundary
    base_setup(40, 8, 6);  t_use_pt = 1; t_szc = 0; t_pid = 16'd256; put_pt(); build_chain(0, 0);
    run_walk("R7", 0);
    base_setup(40, 8, 6);  t_use_pt = 1; t_szc = 0; t_pid = 16'd255; put_pt(); build_chain(1, 0);
    run_walk("R7", 0);
    // R10: start while busy
    base_setup(50, 6, 6);  build_chain(3, 0); run_walk("R10", 1);

    for (int i = 0; i < 300; i++) begin
      build_random();
      run_walk("R5", ($urandom % 4) == 0);
    end
    chk("R9", "addr_hold", 64'(hold_err), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule